// File: doc/BRIEF.md
# Block Floating-Point Output Aligner

This block sits behind an FFT butterfly pipeline that emits block floating-point results. Each complex result carries two exponent parts. The first is a transform-wide global exponent of 5 bits. The second is a 2-bit tag attached to that one word. The block adds the tag to the global exponent to get the word's effective exponent. It subtracts that sum from a programmable universal exponent to get a right-shift amount. It then shifts the 16-bit two's-complement sample arithmetically by that amount, so that every word leaves aligned to the same exponent. When the difference is negative, the shift is forced to its maximum of 15. The universal exponent is meant to be programmed one higher than the plain alignment target, because the tag is simply added.

A complex word arrives as two valid beats: the real part first, then the imaginary part. Both beats go through one shifter, and both use the shift worked out on the real beat. A sequencer tracks the stream. It has three states: `ST_IDLE` (no stream is active), `ST_WAIT_RE` (the next beat is a real part) and `ST_WAIT_IM` (the next beat is an imaginary part). The transitions are as follows:
- START: `ST_IDLE` to `ST_WAIT_IM`, taken on a valid beat that has `in_sof` set. This beat latches the global exponent.
- RE_IN: `ST_WAIT_RE` to `ST_WAIT_IM`, taken on any valid beat.
- PAIR_DONE: `ST_WAIT_IM` to `ST_WAIT_RE`, taken on a valid beat that has `in_eof` clear.
- LAST_DONE: `ST_WAIT_IM` to `ST_IDLE`, taken on a valid beat that has `in_eof` set.

The universal exponent register can only be written in `ST_IDLE`.

Top module: `bfp_norm_top`

## Requirements
- R1: After reset, `out_valid` is 0 and the universal exponent holds 8 (parameter `UEXP_INIT`). A stream that runs with no configuration write is shifted using 8.
- R2: The effective exponent is `g + t`, where `g` is the latched global exponent and `t` is the word's tag. When `u - (g + t) >= 0`, the shift amount is `u - (g + t)`. Here `u` is the universal exponent, which can be 0 to 15.
- R3: When `u - (g + t)` is negative, the shift amount is 15.
- R4: The shift is arithmetic. The result equals the signed sample divided by 2^shift, rounded toward minus infinity. Vacated high bits take copies of the sign bit, and the bits shifted out are dropped.
- R5: Within a word, the first accepted beat is the real part and is output with `out_imag`=0. The second accepted beat is the imaginary part and is output with `out_imag`=1. The imaginary part uses the shift of its real part. The `in_tag` value on an imaginary beat is ignored.
- R6: `in_gexp` is latched only on the START beat. Changes to `in_gexp` during a stream have no effect. `in_sof` on any beat of an active stream is ignored.
- R7: `in_eof` ends the stream only on an imaginary beat. On a real beat it is ignored.
- R8: Each accepted beat appears at the outputs two rising clock edges after it was sampled. Cycles with `in_valid`=0 may fall anywhere between beats and produce `out_valid`=0.
- R9: A `cfg_we` write of `cfg_uexp` takes effect in `ST_IDLE`. A write while a stream is active is ignored.
- R10: A valid beat in `ST_IDLE` with `in_sof`=0 is dropped. It produces no output and does not start a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Universal exponent write strobe |
| cfg_uexp | input | 4 | Universal exponent write value |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | First beat of a transform's output |
| in_eof | input | 1 | Last word of the transform (meaningful on imaginary beat) |
| in_gexp | input | 5 | Global exponent of the transform |
| in_tag | input | 2 | Per-word exponent tag (sampled on real beat) |
| in_data | input | 16 | Two's-complement sample |
| out_valid | output | 1 | Output beat valid |
| out_imag | output | 1 | Output beat is the imaginary part |
| out_data | output | 16 | Aligned sample |

## Verification
If the latched global exponent or the universal exponent were disturbed during a stream, the very next word would come out with the wrong shift, two edges after its beat. A wrong held tag would show only on imaginary outputs, so those are compared separately from the real outputs. If the sequencer's phase slipped, `out_imag` would be inverted from that beat on. It could also make the stream end early, and then later beats would vanish from `out_valid`. The sweep covers every universal exponent, global exponent and tag. Directed cases target each rule about ignored inputs.

// File: rtl/bfp_norm_pkg.sv
package bfp_norm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_RE = 2'd1,
        ST_WAIT_IM = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bfp_norm_seq.sv
module bfp_norm_seq
    import bfp_norm_pkg::*;
#(
    parameter int GW        = 5,
    parameter int TW        = 2,
    parameter int SW        = 4,
    parameter int UEXP_INIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [GW-1:0] in_gexp,
    input  logic [TW-1:0] in_tag,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_uexp,
    output logic          beat_acc,
    output logic          beat_imag,
    output logic          busy,
    output logic [GW-1:0] use_gexp,
    output logic [TW-1:0] use_tag,
    output logic [SW-1:0] uexp_q
);

    seq_state_t    state_q, state_d;
    logic          start;
    logic          real_acc;
    logic [GW-1:0] gexp_q;
    logic [TW-1:0] tag_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    state_d = ST_WAIT_IM;      // START
                end
            end
            ST_WAIT_RE: begin
                if (in_valid) begin
                    state_d = ST_WAIT_IM;      // RE_IN
                end
            end
            ST_WAIT_IM: begin
                if (in_valid) begin
                    state_d = in_eof ? ST_IDLE     // LAST_DONE
                                     : ST_WAIT_RE; // PAIR_DONE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        start     = 1'b0;
        real_acc  = 1'b0;
        beat_acc  = 1'b0;
        beat_imag = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                start    = in_valid && in_sof;
                real_acc = start;
                beat_acc = start;
            end
            ST_WAIT_RE: begin
                real_acc = in_valid;
                beat_acc = in_valid;
            end
            ST_WAIT_IM: begin
                beat_acc  = in_valid;
                beat_imag = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // exponent and tag selection for the beat in flight
    always_comb begin
        use_gexp = start ? in_gexp : gexp_q;
        use_tag  = beat_imag ? tag_q : in_tag;
    end

    // stream-held context and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gexp_q <= '0;
            tag_q  <= '0;
            uexp_q <= SW'(UEXP_INIT);
        end else begin
            if (start) begin
                gexp_q <= in_gexp;
            end
            if (real_acc) begin
                tag_q <= in_tag;
            end
            if (cfg_we && !busy) begin
                uexp_q <= cfg_uexp;
            end
        end
    end

    // R6
    gexp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(gexp_q))
        else $error("global exponent changed inside a stream");

    // R9
    uexp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(uexp_q))
        else $error("universal exponent changed inside a stream");

    // R5
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_IM) |=> $stable(tag_q))
        else $error("held tag changed before imaginary beat");

    // R5
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_IM && in_valid) |=> (state_q != ST_WAIT_IM))
        else $error("two imaginary beats in a row");

endmodule

// File: rtl/bfp_norm_shamt.sv
module bfp_norm_shamt #(
    parameter int GW = 5,
    parameter int TW = 2,
    parameter int SW = 4
) (
    input  logic [SW-1:0] uexp,
    input  logic [GW-1:0] gexp,
    input  logic [TW-1:0] tag,
    output logic [SW-1:0] shamt
);

    localparam int BASEW = (SW > GW) ? SW : GW;
    localparam int DIFW  = BASEW + 2;

    logic signed [DIFW-1:0] diff;
    logic                   neg;

    always_comb begin
        diff  = DIFW'(uexp) - DIFW'(gexp) - DIFW'(tag);
        neg   = diff[DIFW-1];
        shamt = neg ? {SW{1'b1}} : diff[SW-1:0];
    end

    always_comb begin
        if (!$isunknown({uexp, gexp, tag})) begin
            if (DIFW'(uexp) < DIFW'(gexp) + DIFW'(tag)) begin
                // R3
                shamt_trap_chk: assert (shamt == {SW{1'b1}})
                    else $error("negative difference not trapped");
            end else begin
                // R2
                shamt_sum_chk: assert (DIFW'(shamt) + DIFW'(gexp) + DIFW'(tag) == DIFW'(uexp))
                    else $error("shift does not close the exponent gap");
            end
        end
    end

endmodule

// File: rtl/bfp_norm_ashr.sv
module bfp_norm_ashr #(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] sh,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        logic [DW-1:0] shifted;
        assign shifted    = DW'($signed(stg[i]) >>> STEP);
        assign stg[i + 1] = sh[i] ? shifted : stg[i];
    end

    assign dout = stg[SW];

    always_comb begin
        if (!$isunknown({din, sh})) begin
            // R4
            sign_keep_chk: assert (dout[DW-1] == din[DW-1])
                else $error("arithmetic shift lost the sign");
        end
    end

    if ((2 ** SW) - 1 >= DW - 1) begin : g_full_chk
        always_comb begin
            if (!$isunknown({din, sh}) && (sh == {SW{1'b1}})) begin
                // R4
                full_shift_chk: assert (dout == {DW{din[DW-1]}})
                    else $error("maximum shift not all sign bits");
            end
        end
    end

endmodule

// File: rtl/bfp_norm_top.sv
module bfp_norm_top #(
    parameter int DW        = 16,
    parameter int GW        = 5,
    parameter int TW        = 2,
    parameter int SW        = 4,
    parameter int UEXP_INIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_uexp,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [GW-1:0] in_gexp,
    input  logic [TW-1:0] in_tag,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_imag,
    output logic [DW-1:0] out_data
);

    logic          beat_acc;
    logic          beat_imag;
    logic          busy;
    logic [GW-1:0] use_gexp;
    logic [TW-1:0] use_tag;
    logic [SW-1:0] uexp_q;
    logic [SW-1:0] shamt;

    logic          s1_valid;
    logic          s1_imag;
    logic [DW-1:0] s1_data;
    logic [SW-1:0] s1_shamt;
    logic [DW-1:0] s1_shifted;

    bfp_norm_seq #(
        .GW        (GW),
        .TW        (TW),
        .SW        (SW),
        .UEXP_INIT (UEXP_INIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_gexp   (in_gexp),
        .in_tag    (in_tag),
        .cfg_we    (cfg_we),
        .cfg_uexp  (cfg_uexp),
        .beat_acc  (beat_acc),
        .beat_imag (beat_imag),
        .busy      (busy),
        .use_gexp  (use_gexp),
        .use_tag   (use_tag),
        .uexp_q    (uexp_q)
    );

    bfp_norm_shamt #(
        .GW (GW),
        .TW (TW),
        .SW (SW)
    ) u_shamt (
        .uexp  (uexp_q),
        .gexp  (use_gexp),
        .tag   (use_tag),
        .shamt (shamt)
    );

    // stage 1: capture beat and its shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_imag  <= 1'b0;
            s1_data  <= '0;
            s1_shamt <= '0;
        end else begin
            s1_valid <= beat_acc;
            s1_imag  <= beat_imag;
            s1_data  <= in_data;
            s1_shamt <= shamt;
        end
    end

    bfp_norm_ashr #(
        .DW (DW),
        .SW (SW)
    ) u_ashr (
        .din  (s1_data),
        .sh   (s1_shamt),
        .dout (s1_shifted)
    );

    // stage 2: registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_imag  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_imag  <= s1_imag;
            out_data  <= s1_valid ? s1_shifted : '0;
        end
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2))
        else $error("output without an input beat two edges earlier");

    // R10
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && !in_sof) |-> ##2 !out_valid)
        else $error("idle beat without start produced output");

endmodule

// File: tb/bfp_norm_top_test.sv
module bfp_norm_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_uexp = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [4:0]  in_gexp = '0;
    logic [1:0]  in_tag = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_imag;
    logic [15:0] out_data;

    int vecs = 0;
    int fails = 0;
    bit ended = 0;

    // bench model of the requirements
    bit          m_active = 0;
    bit          m_ph = 0;
    int          m_u = 8;
    int          m_g = 0;
    int          m_t = 0;

    // expectation of the beat currently on the inputs
    bit          cur_v = 0;
    bit          cur_i = 0;
    logic [15:0] cur_d = '0;
    string       cur_req = "R1";

    // expectation of the beat sampled one edge earlier
    bit          p_v = 0;
    bit          p_i = 0;
    logic [15:0] p_d = '0;
    string       p_req = "R1";

    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    bfp_norm_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_uexp  (cfg_uexp),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_gexp   (in_gexp),
        .in_tag    (in_tag),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_imag  (out_imag),
        .out_data  (out_data)
    );

    function automatic int calc_sh(int u, int g, int t);
        int d;
        d = u - g - t;
        return (d < 0) ? 15 : d;
    endfunction

    function automatic string sweep_req(int u, int g, int t);
        return (u - g - t < 0) ? "R3" : "R2";
    endfunction

    function automatic logic [15:0] next_lfsr(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // checker: output after edge k reflects the beat sampled at edge k-1
    initial begin
        forever begin
            @(posedge clk);
            #1;
            vecs++;
            if (out_valid !== p_v) begin
                fails++;
                $display("FAIL %s out_valid act=%0b exp=%0b", p_req, out_valid, p_v);
            end else if (p_v) begin
                if (out_imag !== p_i) begin
                    fails++;
                    $display("FAIL %s out_imag act=%0b exp=%0b", p_req, out_imag, p_i);
                end else if (out_data !== p_d) begin
                    fails++;
                    $display("FAIL %s out_data act=%h exp=%h", p_req, out_data, p_d);
                end
            end
            p_v   = cur_v;
            p_i   = cur_i;
            p_d   = cur_d;
            p_req = cur_req;
        end
    end

    task automatic beat(input bit sof, input bit eof, input int g, input int t,
                        input logic [15:0] d, input string req);
        int sh;
        in_valid = 1'b1;
        in_sof   = sof;
        in_eof   = eof;
        in_gexp  = 5'(g);
        in_tag   = 2'(t);
        in_data  = d;
        cfg_we   = 1'b0;
        cur_v    = 0;
        cur_i    = 0;
        cur_req  = req;
        if (!m_active) begin
            if (sof) begin
                m_active = 1;
                m_g      = g;
                m_t      = t;
                m_ph     = 1;
                cur_v    = 1;
            end
        end else if (!m_ph) begin
            m_t   = t;
            m_ph  = 1;
            cur_v = 1;
        end else begin
            cur_v = 1;
            cur_i = 1;
            m_ph  = 0;
            if (eof) m_active = 0;
        end
        sh    = calc_sh(m_u, m_g, m_t);
        cur_d = cur_v ? 16'($signed(d) >>> sh) : 16'h0;
        @(negedge clk);
    endtask

    task automatic gap(input string req);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        cfg_we   = 1'b0;
        cur_v    = 0;
        cur_req  = req;
        @(negedge clk);
    endtask

    task automatic cfg(input int u, input string req);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        cfg_we   = 1'b1;
        cfg_uexp = 4'(u);
        cur_v    = 0;
        cur_req  = req;
        if (!m_active) m_u = u;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R1: outputs idle through reset
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        gap("R1");

        // R1: reset universal exponent 8, g=3 t=1 -> shift 4
        beat(1, 0, 3, 1, 16'h4000, "R1");
        beat(0, 1, 3, 1, 16'hC000, "R1");
        gap("R1");

        // R10: valid beats in idle without start are dropped
        beat(0, 0, 2, 0, 16'h1234, "R10");
        beat(0, 1, 2, 0, 16'h5678, "R10");
        gap("R10");

        // R9: write while idle is taken, write mid-stream is ignored
        cfg(6, "R9");
        beat(1, 0, 1, 1, 16'h7FF0, "R9");
        cfg(0, "R9");
        beat(0, 0, 1, 1, 16'h8010, "R9");
        beat(0, 0, 1, 2, 16'h0F00, "R9");
        beat(0, 1, 1, 2, 16'hF0F0, "R9");
        gap("R9");

        // R6: in_gexp and in_sof ignored within a stream
        cfg(10, "R6");
        beat(1, 0, 2, 0, 16'h6000, "R6");
        beat(0, 0, 9, 0, 16'h9000, "R6");
        beat(1, 0, 17, 1, 16'h3003, "R6");
        beat(1, 0, 0, 3, 16'hA00A, "R6");

        // R5: tag on imaginary beat ignored
        beat(0, 0, 2, 3, 16'h7777, "R5");
        beat(0, 0, 2, 0, 16'h8888, "R5");

        // R7: eof on real beat ignored, ends on imaginary beat
        beat(0, 1, 2, 1, 16'h4444, "R7");
        beat(0, 1, 2, 1, 16'hBBBB, "R7");
        beat(0, 0, 2, 0, 16'h2222, "R7");
        gap("R7");

        // R8: gaps between beats, outputs two edges after each beat
        beat(1, 0, 4, 2, 16'h7F00, "R8");
        gap("R8");
        gap("R8");
        beat(0, 0, 4, 2, 16'h80FF, "R8");
        gap("R8");
        beat(0, 0, 4, 0, 16'h1357, "R8");
        beat(0, 1, 4, 0, 16'hECA9, "R8");
        gap("R8");

        // R2 R3 R4: every universal exponent, global exponent and tag
        for (int u = 0; u < 16; u++) begin
            cfg(u, "R9");
            for (int g = 0; g < 32; g++) begin
                for (int t = 0; t < 4; t++) begin
                    logic [15:0] re, im;
                    lfsr = next_lfsr(lfsr);
                    re   = lfsr;
                    lfsr = next_lfsr(lfsr);
                    im   = lfsr;
                    if (t == 0) begin re = 16'h8000; im = 16'h7FFF; end
                    if (t == 1) begin re = 16'hFFFF; im = 16'h0001; end
                    beat(t == 0, 0, g, t, re, sweep_req(u, g, t));
                    if (g % 3 == 0) gap("R8");
                    beat(0, t == 3, g, t, im, (t == 2) ? "R4" : "R5");
                end
            end
        end
        gap("R2");
        gap("R2");
        gap("R2");
        finish_run();
    end

endmodule